// File: doc/BRIEF.md
# Write Leveling Seed Generator

This block computes the starting write-strobe delay for each byte lane of a memory channel before a write-leveling run. There are nine lanes. Lane 8 carries the check byte. On a start pulse the block takes in the module class, a control-word flag, the current and previous clock speeds and a signed bias term. It then produces one seed per lane, in lane order, on a valid/ready output stream.

The first training pass uses a constant seed that depends on the module class and the speed. A lane override can replace that constant. The second pass rescales the delay that pass 1 found for each lane by the ratio of the new speed to the old one. Before scaling, it removes the delay that the module's register stage adds and also removes the bias. A sequential restoring divider performs the division. Each beat carries two values. The first is the seed itself, which is saved for correcting results later. The second is the value to program, which may be re-encoded into a pre-gross form.

Back-pressure rules: while `sd_valid` is high and `sd_ready` is low, the block holds every output field. A beat is consumed on a clock edge where both are high. The scalar configuration is captured when the start pulse is taken. The per-lane vectors (`prev_dly`, `ovr_vld`, `ovr_seed`) are read while each lane is prepared, so they must stay stable while `busy` is high. `prev_speed` must be nonzero in pass 2.

Top module: `wl_seed_gen`

## Requirements
- R1: In pass 1 (`pass_sel`=0) the raw seed is chosen from the module class in `mod_type`. Unbuffered (0) gives 0x1A, small-outline (1) gives 0x12, load-reduced (3) gives 0xF7, and registered (2) at a speed other than `SLOW_SPEED` gives 0x41, or 0x51 when `cw_bit0` is 1.
- R2: A registered module at exactly `SLOW_SPEED` gets raw seed 0x3B in pass 1, or 0x4B when `cw_bit0` is 1.
- R3: In pass 1, a lane whose bit in `ovr_vld` is 1 uses its byte of `ovr_seed` (lane n at bits 8n+7..8n) as its raw seed. Other lanes keep the default.
- R4: In pass 2 the raw seed is (D + ((P − D − B) × S) / Q) mod 256. P is the lane's byte of `prev_dly`, B is the signed `bias`, S is `speed` and Q is `prev_speed`. The division truncates toward zero.
- R5: The register delay D is 0x20 for a registered module with `cw_bit0`=0, 0x30 for a registered module with `cw_bit0`=1, and 0 for every other class.
- R6: With `adjust_en`=1, `sd_data` is (raw & 0x1F) | 0x20 when raw bit 5 is 1, and (raw & 0x1F) | 0x40 otherwise. With `adjust_en`=0, `sd_data` equals raw.
- R7: `sd_raw` always carries the unadjusted seed of the beat.
- R8: A run emits exactly nine beats, with `sd_lane` going 0 to 8 in order. `sd_last` is 1 only on lane 8.
- R9: While `sd_valid`=1 and `sd_ready`=0, `sd_valid`, `sd_data`, `sd_raw` and `sd_lane` hold their values.
- R10: After reset, `busy` and `sd_valid` are 0. A `start` pulse while `busy`=1 is ignored and does not alter the run in progress.
- R11: A negative P − D − B in pass 2 gives a quotient rounded toward zero, and the 8-bit two's-complement sum is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; taken only when idle |
| pass_sel | input | 1 | 0: pass 1 default seeds; 1: pass 2 scaling |
| mod_type | input | 2 | 0 unbuffered, 1 small-outline, 2 registered, 3 load-reduced |
| cw_bit0 | input | 1 | Register control-word flag |
| adjust_en | input | 1 | Enable pre-gross re-encoding of the output |
| speed | input | SPEED_W | Current clock speed |
| prev_speed | input | SPEED_W | Speed of the previous pass (nonzero) |
| bias | input | 8 | Signed bias subtracted before scaling |
| prev_dly | input | 8*NUM_LANES | Saved pass-1 delays, lane n at bits 8n+7..8n |
| ovr_vld | input | NUM_LANES | Per-lane override enable |
| ovr_seed | input | 8*NUM_LANES | Per-lane override seeds |
| busy | output | 1 | A run is in progress |
| sd_valid | output | 1 | Output beat valid |
| sd_ready | input | 1 | Consumer accepts the beat |
| sd_data | output | 8 | Seed to program (possibly re-encoded) |
| sd_raw | output | 8 | Unadjusted seed to save |
| sd_lane | output | LANE_W | Lane index of the beat |
| sd_last | output | 1 | Beat is lane 8 |

## Verification
A wrong lane counter shows up on the first beat, as a lane out of order or a misplaced `sd_last`. A wrong seed register or re-encoding shows on the same beat as a mismatch between `sd_raw` and `sd_data`. A broken divider step or sign fix-up stays hidden until pass 2. There it corrupts every lane whose scaled value is not exact. Negative differences are exercised on purpose, because a lost sign shows only on those lanes. If the configuration captured at start is lost, every later beat of the run differs. That is why a second start during a run is part of the tests.

// File: rtl/wl_seed_pkg.sv
package wl_seed_pkg;
  localparam int SEED_W = 8;

  typedef enum logic [1:0] {
    MT_UNBUF = 2'd0,
    MT_SMALL = 2'd1,
    MT_REG   = 2'd2,
    MT_LRED  = 2'd3
  } mod_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_DIV  = 2'd2,
    ST_OUT  = 2'd3
  } seq_t;

  // delay added by the module's register stage, in delay units
  function automatic logic [SEED_W-1:0] reg_delay(input mod_t mt, input logic cw);
    if (mt == MT_REG) return cw ? 8'h30 : 8'h20;
    return 8'h00;
  endfunction
endpackage

// File: rtl/wl_seed_default.sv
module wl_seed_default
  import wl_seed_pkg::*;
(
  input  mod_t              mod_type,
  input  logic              cw_bit0,
  input  logic              slow,
  output logic [SEED_W-1:0] seed
);
  always_comb begin
    case (mod_type)
      MT_REG:   seed = slow ? (cw_bit0 ? 8'h4B : 8'h3B) : (cw_bit0 ? 8'h51 : 8'h41);
      MT_SMALL: seed = 8'h12;
      MT_LRED:  seed = 8'hF7;
      default:  seed = 8'h1A;
    endcase
  end
endmodule

// File: rtl/wl_seed_encode.sv
module wl_seed_encode
  import wl_seed_pkg::*;
(
  input  logic              en,
  input  logic [SEED_W-1:0] raw,
  output logic [SEED_W-1:0] coded
);
  always_comb begin
    if (!en)         coded = raw;
    else if (raw[5]) coded = {3'b001, raw[4:0]};
    else             coded = {3'b010, raw[4:0]};
  end
endmodule

// File: rtl/wl_seed_div.sv
module wl_seed_div #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 16,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [OUT_W-1:0] quo,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_r;
  logic [DEN_W-1:0] rem_r;
  logic [CNT_W-1:0] cnt_r;
  logic             run_r;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   trial;

  assign shifted = {rem_r, q_r[NUM_W-1]};
  assign trial   = shifted - {1'b0, den};
  assign quo     = q_r[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      rem_r <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      q_r   <= num;
      rem_r <= '0;
      cnt_r <= CNT_W'(NUM_W);
      run_r <= 1'b1;
      done  <= 1'b0;
    end else if (run_r) begin
      if (!trial[DEN_W]) rem_r <= trial[DEN_W-1:0];
      else               rem_r <= shifted[DEN_W-1:0];
      q_r   <= {q_r[NUM_W-2:0], ~trial[DEN_W]};
      cnt_r <= cnt_r - 1'b1;
      if (cnt_r == CNT_W'(1)) begin
        run_r <= 1'b0;
        done  <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/wl_seed_gen.sv
module wl_seed_gen
  import wl_seed_pkg::*;
#(
  parameter int NUM_LANES  = 9,
  parameter int SPEED_W    = 16,
  parameter int SLOW_SPEED = 333,
  localparam int LANE_W    = $clog2(NUM_LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        pass_sel,
  input  logic [1:0]                  mod_type,
  input  logic                        cw_bit0,
  input  logic                        adjust_en,
  input  logic [SPEED_W-1:0]          speed,
  input  logic [SPEED_W-1:0]          prev_speed,
  input  logic [SEED_W-1:0]           bias,
  input  logic [NUM_LANES*SEED_W-1:0] prev_dly,
  input  logic [NUM_LANES-1:0]        ovr_vld,
  input  logic [NUM_LANES*SEED_W-1:0] ovr_seed,
  output logic                        busy,
  output logic                        sd_valid,
  input  logic                        sd_ready,
  output logic [SEED_W-1:0]           sd_data,
  output logic [SEED_W-1:0]           sd_raw,
  output logic [LANE_W-1:0]           sd_lane,
  output logic                        sd_last
);
  localparam int DIFF_W = SEED_W + 2;
  localparam int NUM_W  = DIFF_W + SPEED_W;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  // per-lane views of the flat vectors
  logic [SEED_W-1:0] prev_arr [NUM_LANES];
  logic [SEED_W-1:0] ovr_arr  [NUM_LANES];
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign prev_arr[g] = prev_dly[g*SEED_W +: SEED_W];
    assign ovr_arr[g]  = ovr_seed[g*SEED_W +: SEED_W];
  end

  seq_t               st_q;
  logic [LANE_W-1:0]  lane_q;
  logic [SEED_W-1:0]  raw_q;
  logic               cfg_pass, cfg_cw, cfg_adj;
  mod_t               cfg_mt;
  logic [SPEED_W-1:0] cfg_speed, cfg_pspeed;
  logic [SEED_W-1:0]  cfg_bias;

  // pass 1 path
  logic [SEED_W-1:0] def_seed, p1_seed;
  wl_seed_default u_default (
    .mod_type (cfg_mt),
    .cw_bit0  (cfg_cw),
    .slow     (cfg_speed == SPEED_W'(SLOW_SPEED)),
    .seed     (def_seed)
  );
  assign p1_seed = ovr_vld[lane_q] ? ovr_arr[lane_q] : def_seed;

  // pass 2 path
  logic [SEED_W-1:0] rdly;
  logic signed [DIFF_W-1:0] diff_s;
  logic [DIFF_W-1:0] mag;
  logic              neg;
  logic [NUM_W-1:0]  prod;
  logic [SEED_W-1:0] quo, quo_s, p2_seed;
  logic              div_start, div_done;

  assign rdly   = reg_delay(cfg_mt, cfg_cw);
  assign diff_s = $signed({2'b00, prev_arr[lane_q]}) - $signed({2'b00, rdly})
                - $signed({{2{cfg_bias[SEED_W-1]}}, cfg_bias});
  assign neg    = diff_s[DIFF_W-1];
  assign mag    = neg ? DIFF_W'(-diff_s) : DIFF_W'(diff_s);
  assign prod   = NUM_W'(mag) * NUM_W'(cfg_speed);
  assign div_start = (st_q == ST_PREP) && cfg_pass;

  wl_seed_div #(.NUM_W(NUM_W), .DEN_W(SPEED_W), .OUT_W(SEED_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (prod),
    .den   (cfg_pspeed),
    .quo   (quo),
    .done  (div_done)
  );
  assign quo_s   = neg ? SEED_W'(-quo) : quo;
  assign p2_seed = rdly + quo_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      lane_q     <= '0;
      raw_q      <= '0;
      cfg_pass   <= 1'b0;
      cfg_cw     <= 1'b0;
      cfg_adj    <= 1'b0;
      cfg_mt     <= MT_UNBUF;
      cfg_speed  <= '0;
      cfg_pspeed <= '0;
      cfg_bias   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          cfg_pass   <= pass_sel;
          cfg_cw     <= cw_bit0;
          cfg_adj    <= adjust_en;
          cfg_mt     <= mod_t'(mod_type);
          cfg_speed  <= speed;
          cfg_pspeed <= prev_speed;
          cfg_bias   <= bias;
          lane_q     <= '0;
          st_q       <= ST_PREP;
        end
        ST_PREP: begin
          if (cfg_pass) st_q <= ST_DIV;
          else begin
            raw_q <= p1_seed;
            st_q  <= ST_OUT;
          end
        end
        ST_DIV: if (div_done) begin
          raw_q <= p2_seed;
          st_q  <= ST_OUT;
        end
        default: if (sd_ready) begin
          if (lane_q == LAST_LANE) st_q <= ST_IDLE;
          else begin
            lane_q <= lane_q + 1'b1;
            st_q   <= ST_PREP;
          end
        end
      endcase
    end
  end

  wl_seed_encode u_encode (
    .en    (cfg_adj),
    .raw   (raw_q),
    .coded (sd_data)
  );

  assign busy     = (st_q != ST_IDLE);
  assign sd_valid = (st_q == ST_OUT);
  assign sd_raw   = raw_q;
  assign sd_lane  = lane_q;
  assign sd_last  = (lane_q == LAST_LANE);
endmodule

// File: rtl/wl_seed_gen_chk.sv
module wl_seed_gen_chk #(
  parameter int NUM_LANES = 9,
  localparam int LANE_W   = $clog2(NUM_LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sd_valid,
  input logic              sd_ready,
  input logic [7:0]        sd_data,
  input logic [7:0]        sd_raw,
  input logic [LANE_W-1:0] sd_lane,
  input logic              sd_last
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid && !sd_ready |=> sd_valid && $stable(sd_data) && $stable(sd_raw) && $stable(sd_lane));

  a_r8_last_lane: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid |-> (sd_last == (sd_lane == LANE_W'(NUM_LANES - 1))));

  a_r8_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid |-> (int'(sd_lane) < NUM_LANES));

  a_r6_adjust_form: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid && (sd_data != sd_raw) |->
      !sd_data[7] && $onehot(sd_data[6:5]) && (sd_data[4:0] == sd_raw[4:0]));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sd_valid);
endmodule

bind wl_seed_gen wl_seed_gen_chk #(.NUM_LANES(NUM_LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sd_valid(sd_valid), .sd_ready(sd_ready),
  .sd_data(sd_data), .sd_raw(sd_raw), .sd_lane(sd_lane), .sd_last(sd_last)
);

// File: tb/wl_seed_gen_tb_top.sv
module wl_seed_gen_tb_top;
  localparam int NL = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pass_sel = 1'b0, cw_bit0 = 1'b0, adjust_en = 1'b0, sd_ready = 1'b0;
  logic [1:0]  mod_type = 2'd0;
  logic [15:0] speed = 16'd533, prev_speed = 16'd400;
  logic [7:0]  bias = 8'd0;
  logic [NL*8-1:0] prev_dly = '0, ovr_seed = '0;
  logic [NL-1:0]   ovr_vld = '0;
  logic busy, sd_valid, sd_last;
  logic [7:0] sd_data, sd_raw;
  logic [3:0] sd_lane;

  int n_tests = 0, n_fail = 0;
  int exp_raw [NL];
  int exp_out [NL];

  always #4 clk = ~clk;

  wl_seed_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pass_sel(pass_sel), .mod_type(mod_type),
    .cw_bit0(cw_bit0), .adjust_en(adjust_en), .speed(speed), .prev_speed(prev_speed),
    .bias(bias), .prev_dly(prev_dly), .ovr_vld(ovr_vld), .ovr_seed(ovr_seed),
    .busy(busy), .sd_valid(sd_valid), .sd_ready(sd_ready), .sd_data(sd_data),
    .sd_raw(sd_raw), .sd_lane(sd_lane), .sd_last(sd_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int f_regdly(input int mt, input int cw);
    if (mt == 2) return cw ? 'h30 : 'h20;   // R5
    return 0;
  endfunction

  function automatic int f_default(input int mt, input int cw, input int sp);
    case (mt)
      0: return 'h1A;
      1: return 'h12;
      3: return 'hF7;
      default: return (sp == 333) ? (cw ? 'h4B : 'h3B) : (cw ? 'h51 : 'h41);
    endcase
  endfunction

  function automatic int f_scale(input int p, input int mt, input int cw, input int b,
                                 input int sp, input int psp);
    int d;
    d = f_regdly(mt, cw);
    return (d + ((p - d - b) * sp) / psp) & 255;
  endfunction

  function automatic int f_adj(input int en, input int r);
    if (!en) return r;
    return ((r & 'h20) != 0) ? ((r & 'h1F) | 'h20) : ((r & 'h1F) | 'h40);
  endfunction

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // consume nine beats; mode 1 toggles ready to apply back-pressure
  task automatic collect(input string req, input int mode);
    int got = 0, guard = 0, hold_lane = 0, hold_data = 0;
    bit held = 0;
    while (got < NL && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (held) begin
        chk(sd_valid && int'(sd_lane) == hold_lane && int'(sd_data) == hold_data,
            "R9 hold", int'(sd_data), hold_data);
        held = 0;
      end
      sd_ready = (mode == 0) ? 1'b1 : ((guard % 3) == 0);
      if (sd_valid && !sd_ready) begin
        held = 1; hold_lane = int'(sd_lane); hold_data = int'(sd_data);
      end
      if (sd_valid && sd_ready) begin
        chk(int'(sd_lane) == got, {req, " R8 lane"}, int'(sd_lane), got);
        chk(sd_last == (got == NL - 1), {req, " R8 last"}, int'(sd_last), int'(got == NL - 1));
        chk(int'(sd_raw) == exp_raw[got], {req, " R7 raw"}, int'(sd_raw), exp_raw[got]);
        chk(int'(sd_data) == exp_out[got], {req, " data"}, int'(sd_data), exp_out[got]);
        got++;
      end
    end
    @(negedge clk);
    sd_ready = 1'b0;
    chk(got == NL, {req, " beat count"}, got, NL);
  endtask

  task automatic t_reset();
    chk(!busy && !sd_valid, "R10 reset", {busy, sd_valid}, 0);
  endtask

  task automatic t_pass1_types();
    for (int mt = 0; mt < 4; mt++) begin
      for (int cw = 0; cw < 2; cw++) begin
        pass_sel = 0; mod_type = 2'(mt); cw_bit0 = cw[0]; adjust_en = 0;
        speed = 16'd533; ovr_vld = '0;
        for (int l = 0; l < NL; l++) begin
          exp_raw[l] = f_default(mt, cw, 533); exp_out[l] = exp_raw[l];
        end
        kick();
        collect("R1 default", 0);
      end
    end
  endtask

  task automatic t_pass1_slow();
    for (int cw = 0; cw < 2; cw++) begin
      pass_sel = 0; mod_type = 2'd2; cw_bit0 = cw[0]; adjust_en = 0;
      speed = 16'd333; ovr_vld = '0;
      for (int l = 0; l < NL; l++) begin
        exp_raw[l] = cw ? 'h4B : 'h3B; exp_out[l] = exp_raw[l];   // R2
      end
      kick();
      collect("R2 slow registered", 0);
    end
  endtask

  task automatic t_override();
    pass_sel = 0; mod_type = 2'd0; cw_bit0 = 0; adjust_en = 0; speed = 16'd533;
    ovr_vld = '0; ovr_vld[2] = 1'b1; ovr_vld[8] = 1'b1; ovr_vld[5] = 1'b0;
    for (int l = 0; l < NL; l++) ovr_seed[l*8 +: 8] = 8'(8'h60 + l);
    for (int l = 0; l < NL; l++) begin
      exp_raw[l] = ovr_vld[l] ? ('h60 + l) : 'h1A; exp_out[l] = exp_raw[l];   // R3
    end
    kick();
    collect("R3 override", 0);
    ovr_vld = '0;
  endtask

  task automatic t_adjust();
    for (int mt = 0; mt < 4; mt += 3) begin
      pass_sel = 0; mod_type = 2'(mt); cw_bit0 = 0; adjust_en = 1; speed = 16'd533;
      for (int l = 0; l < NL; l++) begin
        exp_raw[l] = f_default(mt, 0, 533); exp_out[l] = f_adj(1, exp_raw[l]);   // R6
      end
      kick();
      collect("R6 adjust", 0);
    end
  endtask

  task automatic t_pass2(input int mt, input int cw, input int b, input int sp,
                         input int psp, input int adj, input int base, input string req);
    pass_sel = 1; mod_type = 2'(mt); cw_bit0 = cw[0]; adjust_en = adj[0];
    speed = 16'(sp); prev_speed = 16'(psp); bias = 8'(b);
    for (int l = 0; l < NL; l++) begin
      prev_dly[l*8 +: 8] = 8'(base + l * 19);
      exp_raw[l] = f_scale((base + l * 19) & 255, mt, cw, b, sp, psp);
      exp_out[l] = f_adj(adj, exp_raw[l]);
    end
    kick();
    collect(req, 0);
  endtask

  task automatic t_backpressure();
    pass_sel = 1; mod_type = 2'd2; cw_bit0 = 0; adjust_en = 1;
    speed = 16'd667; prev_speed = 16'd400; bias = 8'd2;
    for (int l = 0; l < NL; l++) begin
      prev_dly[l*8 +: 8] = 8'('h28 + l * 7);
      exp_raw[l] = f_scale('h28 + l * 7, 2, 0, 2, 667, 400);
      exp_out[l] = f_adj(1, exp_raw[l]);
    end
    kick();
    collect("R9 back-pressure", 1);
  endtask

  task automatic t_busy_start();
    pass_sel = 0; mod_type = 2'd1; cw_bit0 = 0; adjust_en = 0; speed = 16'd533; ovr_vld = '0;
    for (int l = 0; l < NL; l++) begin
      exp_raw[l] = 'h12; exp_out[l] = 'h12;
    end
    kick();
    repeat (3) @(negedge clk);
    mod_type = 2'd3; pass_sel = 1; adjust_en = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect("R10 start while busy", 0);
    repeat (3) @(negedge clk);
    chk(!busy && !sd_valid, "R10 idle after run", {busy, sd_valid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass1_types();
    t_pass1_slow();
    t_override();
    t_adjust();
    t_pass2(2, 1, 3,   533, 400, 0, 'h30, "R4 R5 registered cw1");
    t_pass2(2, 0, -4,  800, 533, 1, 'h22, "R4 R5 registered cw0");
    t_pass2(0, 0, 0,   667, 400, 1, 'h05, "R4 unbuffered");
    t_pass2(2, 0, 5,   667, 333, 0, 'h00, "R11 negative");
    t_pass2(3, 0, 10,  533, 400, 0, 'h02, "R11 load-reduced");
    t_backpressure();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule